// File: doc/BRIEF.md
# Maskable Date-Time Alarm Matcher

This block watches a running calendar clock and raises an alarm when the clock reaches a programmed moment. Four alarm targets are compared with the live time: day-of-month, hour, minute and second. All values are two-digit BCD bytes. Each target has its own enable bit. A target that is switched off is treated as always equal. One comparator can therefore repeat once a minute (seconds only), once an hour, once a day, once a month, or fire at one exact moment.

The comparison is sampled only on the one-second tick. A hit sets a sticky alarm flag, which stays set until software pulses the clear strobe. The interrupt line is the flag gated by the interrupt enable. Loading and range-checking the alarm targets happens elsewhere; this block takes them as plain inputs. None of its pins carry a data stream, so every pin is a plain level or strobe with no valid/ready handshake.

Top module: `alarm_matcher`

## Requirements
- R1: The four targets are 8-bit BCD bytes for day-of-month, hour, minute and second, each compared for exact equality with its live counterpart.
- R2: `alm_en` bit 0 enables seconds, bit 1 minutes, bit 2 hours and bit 3 day-of-month. A field whose bit is 0 counts as matching whatever its values are.
- R3: With all four enables set, a tick on which every field equals its target sets the flag. A difference in any single field leaves the flag clear.
- R4: With only the seconds enable set, the flag is set on a tick whose live seconds equal the target, regardless of the other three live fields.
- R5: `irq` is high exactly when the flag is set and `irq_en` is high. Changing `irq_en` changes `irq` in the same cycle.
- R6: Once set, the flag holds through later ticks with or without a match until `flag_clr` is high on a clock edge. It reads 0 from the following cycle.
- R7: With `alm_en` equal to 0, the flag is never set, even when every live field equals its target.
- R8: Matching is evaluated only on a clock edge where `tick` is high. The flag reads 1 in the cycle after that edge. A standing match with `tick` low never sets the flag.
- R9: When a match on a tick and `flag_clr` arrive on the same edge, the flag is set.
- R10: While `rst_n` is low, the flag and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-second tick, one cycle wide |
| cur_date | input | FIELD_W | Live day-of-month, BCD |
| cur_hour | input | FIELD_W | Live hour, BCD |
| cur_min | input | FIELD_W | Live minute, BCD |
| cur_sec | input | FIELD_W | Live second, BCD |
| alm_date | input | FIELD_W | Target day-of-month, BCD |
| alm_hour | input | FIELD_W | Target hour, BCD |
| alm_min | input | FIELD_W | Target minute, BCD |
| alm_sec | input | FIELD_W | Target second, BCD |
| alm_en | input | 4 | Field enables: bit 0 sec, 1 min, 2 hour, 3 date |
| flag_clr | input | 1 | Clears the sticky flag |
| irq_en | input | 1 | Alarm interrupt enable |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq | output | 1 | Active-high interrupt |

## Verification
The assertions assume that `tick` and `flag_clr` are sampled as clean synchronous pulses. They also assume the live and target fields are stable around the clock edge on which `tick` is high, since the checker re-evaluates the match from those same pins. The bench drives every input on the falling edge, holds each `tick` and `flag_clr` pulse for exactly one cycle, and changes the field values only between ticks. This keeps every stimulus inside those assumptions.

// File: rtl/alarm_match_pkg.sv
package alarm_match_pkg;
  localparam int unsigned NUM_FIELDS = 4;
  localparam int unsigned BCD_W      = 8;

  // Enable bit position per field; the order is part of the pin contract.
  typedef enum int unsigned {
    FLD_SEC  = 0,
    FLD_MIN  = 1,
    FLD_HOUR = 2,
    FLD_DATE = 3
  } field_idx_e;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] live,
  input  logic [W-1:0] target,
  input  logic         enable,
  output logic         hit
);
  // A masked field never blocks the alarm.
  always_comb hit = !enable || (live == target);
endmodule

// File: rtl/alarm_match_reduce.sv
module alarm_match_reduce #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] hits,
  input  logic [N-1:0] enables,
  output logic         match
);
  // At least one field must be armed, otherwise all-masked would fire every tick.
  always_comb match = (&hits) && (|enables);
endmodule

// File: rtl/alarm_flag_reg.sv
module alarm_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;   // set beats clear
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/alarm_matcher.sv
module alarm_matcher #(
  parameter int unsigned FIELD_W = alarm_match_pkg::BCD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [FIELD_W-1:0] cur_date,
  input  logic [FIELD_W-1:0] cur_hour,
  input  logic [FIELD_W-1:0] cur_min,
  input  logic [FIELD_W-1:0] cur_sec,
  input  logic [FIELD_W-1:0] alm_date,
  input  logic [FIELD_W-1:0] alm_hour,
  input  logic [FIELD_W-1:0] alm_min,
  input  logic [FIELD_W-1:0] alm_sec,
  input  logic [3:0]         alm_en,
  input  logic               flag_clr,
  input  logic               irq_en,
  output logic               alarm_flag,
  output logic               irq
);
  import alarm_match_pkg::*;
  localparam int unsigned NF = NUM_FIELDS;

  logic [FIELD_W-1:0] live_v [NF];
  logic [FIELD_W-1:0] tgt_v  [NF];
  logic [NF-1:0]      hit_v;
  logic               all_match;
  logic               set_now;

  always_comb begin
    live_v[FLD_SEC]  = cur_sec;
    live_v[FLD_MIN]  = cur_min;
    live_v[FLD_HOUR] = cur_hour;
    live_v[FLD_DATE] = cur_date;
    tgt_v[FLD_SEC]   = alm_sec;
    tgt_v[FLD_MIN]   = alm_min;
    tgt_v[FLD_HOUR]  = alm_hour;
    tgt_v[FLD_DATE]  = alm_date;
  end

  for (genvar gi = 0; gi < NF; gi++) begin : g_cmp
    alarm_field_cmp #(.W(FIELD_W)) u_cmp (
      .live   (live_v[gi]),
      .target (tgt_v[gi]),
      .enable (alm_en[gi]),
      .hit    (hit_v[gi])
    );
  end

  alarm_match_reduce #(.N(NF)) u_reduce (
    .hits    (hit_v),
    .enables (alm_en),
    .match   (all_match)
  );

  always_comb set_now = tick && all_match;

  alarm_flag_reg u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (set_now),
    .clr   (flag_clr),
    .flag  (alarm_flag)
  );

  always_comb irq = alarm_flag && irq_en;
endmodule

// File: rtl/alarm_matcher_chk.sv
module alarm_matcher_chk #(
  parameter int unsigned FIELD_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic [FIELD_W-1:0] cur_date,
  input logic [FIELD_W-1:0] cur_hour,
  input logic [FIELD_W-1:0] cur_min,
  input logic [FIELD_W-1:0] cur_sec,
  input logic [FIELD_W-1:0] alm_date,
  input logic [FIELD_W-1:0] alm_hour,
  input logic [FIELD_W-1:0] alm_min,
  input logic [FIELD_W-1:0] alm_sec,
  input logic [3:0]         alm_en,
  input logic               flag_clr,
  input logic               irq_en,
  input logic               alarm_flag,
  input logic               irq
);
  logic ref_match;
  always_comb ref_match = (alm_en != 4'd0)
    && (!alm_en[0] || cur_sec  == alm_sec)
    && (!alm_en[1] || cur_min  == alm_min)
    && (!alm_en[2] || cur_hour == alm_hour)
    && (!alm_en[3] || cur_date == alm_date);

  AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    tick && ref_match |=> alarm_flag);                                   // R3
  AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(tick));                                  // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_flag && !flag_clr |=> alarm_flag);                             // R6
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_flag && flag_clr && !(tick && ref_match) |=> !alarm_flag);     // R6
  AST_NO_ENABLE_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_flag && alm_en == 4'd0 |=> !alarm_flag);                      // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);                                                   // R5
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> alarm_flag);                                                 // R5
endmodule

bind alarm_matcher alarm_matcher_chk #(.FIELD_W(FIELD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick),
  .cur_date(cur_date), .cur_hour(cur_hour), .cur_min(cur_min), .cur_sec(cur_sec),
  .alm_date(alm_date), .alm_hour(alm_hour), .alm_min(alm_min), .alm_sec(alm_sec),
  .alm_en(alm_en), .flag_clr(flag_clr), .irq_en(irq_en),
  .alarm_flag(alarm_flag), .irq(irq)
);

// File: tb/tb_alarm_matcher.sv
module tb_alarm_matcher;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] cur_date = '0, cur_hour = '0, cur_min = '0, cur_sec = '0;
  logic [7:0] alm_date = '0, alm_hour = '0, alm_min = '0, alm_sec = '0;
  logic [3:0] alm_en = '0;
  logic       flag_clr = 1'b0;
  logic       irq_en = 1'b0;
  logic       alarm_flag, irq;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  alarm_matcher dut (.*);

  task automatic check(string req, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic set_live(logic [7:0] d, h, m, s);
    @(negedge clk);
    cur_date = d; cur_hour = h; cur_min = m; cur_sec = s;
  endtask

  task automatic set_alarm(logic [7:0] d, h, m, s, logic [3:0] en);
    @(negedge clk);
    alm_date = d; alm_hour = h; alm_min = m; alm_sec = s; alm_en = en;
  endtask

  // Tick pulse on one edge; on return the flag has been updated.
  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 flag in reset", alarm_flag, 1'b0);
    check("R10 irq in reset", irq, 1'b0);
  endtask

  task automatic t_exact_match();
    irq_en = 1'b1;
    set_alarm(8'h29, 8'h23, 8'h59, 8'h58, 4'hF);
    set_live(8'h29, 8'h23, 8'h59, 8'h58);
    pulse_tick();
    check("R3 R1 exact match sets flag", alarm_flag, 1'b1);
    check("R5 irq follows flag", irq, 1'b1);
    pulse_tick();
    check("R6 flag holds", alarm_flag, 1'b1);
    pulse_clear();
    check("R6 clear drops flag", alarm_flag, 1'b0);
  endtask

  task automatic t_single_mismatch();
    set_live(8'h28, 8'h23, 8'h59, 8'h58);
    pulse_tick();
    check("R3 date differs", alarm_flag, 1'b0);
    set_live(8'h29, 8'h22, 8'h59, 8'h58);
    pulse_tick();
    check("R3 hour differs", alarm_flag, 1'b0);
    set_live(8'h29, 8'h23, 8'h58, 8'h58);
    pulse_tick();
    check("R3 minute differs", alarm_flag, 1'b0);
    set_live(8'h29, 8'h23, 8'h59, 8'h59);
    pulse_tick();
    check("R3 second differs", alarm_flag, 1'b0);
  endtask

  task automatic t_seconds_only();
    set_alarm(8'h01, 8'h00, 8'h00, 8'h30, 4'b0001);
    set_live(8'h15, 8'h07, 8'h42, 8'h29);
    pulse_tick();
    check("R4 seconds differ", alarm_flag, 1'b0);
    set_live(8'h15, 8'h07, 8'h42, 8'h30);
    pulse_tick();
    check("R4 seconds-only fires", alarm_flag, 1'b1);
    pulse_clear();
    set_live(8'h31, 8'h12, 8'h43, 8'h30);
    pulse_tick();
    check("R4 fires next minute", alarm_flag, 1'b1);
    pulse_clear();
  endtask

  task automatic t_masked_fields();
    set_alarm(8'h10, 8'h08, 8'h15, 8'h00, 4'b0110);
    set_live(8'h22, 8'h08, 8'h15, 8'h47);
    pulse_tick();
    check("R2 masked date and sec ignored", alarm_flag, 1'b1);
    pulse_clear();
  endtask

  task automatic t_no_enable();
    set_alarm(8'h05, 8'h05, 8'h05, 8'h05, 4'b0000);
    set_live(8'h05, 8'h05, 8'h05, 8'h05);
    pulse_tick();
    pulse_tick();
    check("R7 no enable never fires", alarm_flag, 1'b0);
  endtask

  task automatic t_no_tick();
    set_alarm(8'h05, 8'h05, 8'h05, 8'h05, 4'hF);
    repeat (5) @(negedge clk);
    check("R8 match without tick", alarm_flag, 1'b0);
    @(negedge clk); tick = 1'b1;
    @(posedge clk); #1;
    check("R8 not before edge", alarm_flag, 1'b1);
    @(negedge clk); tick = 1'b0;
    pulse_clear();
    repeat (3) @(negedge clk);
    check("R8 no re-set after clear", alarm_flag, 1'b0);
  endtask

  task automatic t_set_beats_clear();
    @(negedge clk); tick = 1'b1; flag_clr = 1'b1;
    @(negedge clk); tick = 1'b0; flag_clr = 1'b0;
    check("R9 set wins over clear", alarm_flag, 1'b1);
    pulse_clear();
  endtask

  task automatic t_irq_gate();
    irq_en = 1'b0;
    pulse_tick();
    check("R5 flag set with irq off", alarm_flag, 1'b1);
    check("R5 irq masked", irq, 1'b0);
    irq_en = 1'b1; #1;
    check("R5 irq enabled", irq, 1'b1);
    pulse_clear();
    check("R5 irq drops with flag", irq, 1'b0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_exact_match();
    t_single_mismatch();
    t_seconds_only();
    t_masked_fields();
    t_no_enable();
    t_no_tick();
    t_set_beats_clear();
    t_irq_gate();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule